// File: doc/BRIEF.md
# Receive Packet Framer

This block marks out received packets for a radio receiver. A correlator front end, which is not part of the block, gives it one strobe per symbol period. With each strobe come a correlation-hit flag, a flag that says the start-of-packet marker matched, and sometimes a decoded byte. The framer decides when a packet begins. It can take the first byte as a length field. It ends the packet either by counting bytes or by counting a run of symbols with no correlation. Every byte it passes on carries a tag, so that a later CRC checker can find the check bytes.

Start detection has two modes. With framing on, the marker must match on two strobes in a row. With framing off, two correlation hits in a row count as a start. The length field only works when framing is on. With the length field, the end of the packet comes from the byte count. Without it, the end comes when a set number of symbols pass with no correlation, with a hard cap on the byte count. When a packet ends, or its length field is rejected, the block goes straight back to searching.

Top module: `rx_pkt_framer`

## Requirements
- R1: With `cfg_framing_en`=1, `sop_match` high on two strobes in a row starts a packet. `sop_pulse` and `pkt_active` go high one clock after the second strobe. Correlation hits alone, or marker matches that are not in a row, do not start a packet.
- R2: With `cfg_framing_en`=0, `corr_hit` high on two strobes in a row starts a packet. `cfg_len_en` has no effect in this mode.
- R3: In length mode (framing and length both enabled), the first accepted byte after the start is output with tag 0 (length). If its value is above 40, `err_pulse` is raised together with that byte, no `eop_pulse` is given, and the block returns to searching.
- R4: In length mode with length value L, L bytes follow with tag 1 (payload). If `cfg_crc_en`=1, two more bytes follow with tag 2 (CRC). `eop_pulse` comes with the last of these bytes. If L=0 and the CRC is off, `eop_pulse` comes with the length byte.
- R5: Without the length field, every byte has tag 1. A counter counts strobes in a row with `corr_hit` low, and a hit clears it. `eop_pulse` is raised one clock after the strobe on which the count reaches `cfg_gap_lim`.
- R6: `cfg_gap_lim`=0 turns off the end condition based on missed correlations. Without the length field, a packet always ends with `eop_pulse` on its 40th byte.
- R7: `pkt_active` is low in the cycle that carries `eop_pulse` or `err_pulse`. After that, bytes and single matches are ignored (no output) until a new start made of two fresh strobes.
- R8: Inputs count only in cycles with `sym_stb` high. Cycles without a strobe neither break a marker pair nor count as misses. Marker matches inside a packet do not restart it.
- R9: After reset, `pkt_active`, `dout_vld`, `sop_pulse`, `eop_pulse` and `err_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_stb | input | 1 | One pulse per symbol period; inputs below are valid with it |
| corr_hit | input | 1 | Correlation detected this symbol |
| sop_match | input | 1 | Start-of-packet marker symbol matched |
| din_vld | input | 1 | A decoded byte completes this symbol |
| din | input | 8 | Decoded byte |
| cfg_framing_en | input | 1 | Marker-based start enable |
| cfg_len_en | input | 1 | Length field enable (valid only with framing) |
| cfg_crc_en | input | 1 | Two CRC bytes follow the payload |
| cfg_gap_lim | input | 4 | Missed-correlation limit, 0 = off |
| pkt_active | output | 1 | Packet in progress |
| dout_vld | output | 1 | Output byte valid |
| dout | output | 8 | Output byte |
| dout_tag | output | 2 | 0 length, 1 payload, 2 CRC |
| sop_pulse | output | 1 | Packet start, one clock |
| eop_pulse | output | 1 | Packet end, one clock |
| err_pulse | output | 1 | Length field out of range, one clock |

## Verification
If the internal byte or CRC count is wrong, `eop_pulse` appears early or late against a known byte. The tag on that byte or the next one is also wrong, one clock after the strobe in question. If the run counter does not clear, the end pulse comes too early in a sequence where a hit breaks up the misses. If the start pair flag is stale, `sop_pulse` appears after one matching strobe. The scoreboard compares every output event in order and flags any event it did not expect, so each of these errors shows up within a cycle of the strobe that causes it.

// File: rtl/rxf_pkg.sv
// Shared types and constants for the receive packet framer.
package rxf_pkg;
    // Byte tag carried on the output stream
    typedef enum logic [1:0] {
        TAG_LEN = 2'd0,
        TAG_PAY = 2'd1,
        TAG_CRC = 2'd2
    } tag_e;

    // Number of check bytes that follow the payload when CRC is enabled
    localparam int CRC_BYTES = 2;
endpackage

// File: rtl/rxf_start_det.sv
// Start detector: flags a packet start when the chosen qualifier (marker
// match or correlation hit) is seen on two strobes in a row.
// Assumes: arm is high only while the framer searches; the pair history
// is cleared whenever it is low, so each start needs two fresh strobes.
module rxf_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic sym_stb,
    input  logic framing_en,
    input  logic sop_match,
    input  logic corr_hit,
    output logic start
);
    logic cand;
    logic prev_q;

    // Pick the qualifier for the active start mode
    always_comb cand = framing_en ? sop_match : corr_hit;

    // Remember whether the previous strobe qualified
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) prev_q <= 1'b0;
        else if (sym_stb)   prev_q <= cand;
    end

    // Start when this strobe and the previous one both qualify
    always_comb start = arm && sym_stb && cand && prev_q;
endmodule

// File: rtl/rxf_len_track.sv
// Length tracker: after the length byte is loaded it counts the payload
// bytes and then the CRC bytes, and gives the tag and the last-byte flag
// for the next accepted byte.
// Assumes: load and take never come in the same cycle; len_val is within range.
module rxf_len_track
    import rxf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             take,
    input  logic             crc_en,
    input  logic [CNT_W-1:0] len_val,
    output tag_e             cur_tag,
    output logic             last
);
    logic [CNT_W-1:0] pay_left;
    logic [1:0]       crc_left;

    // Load the counts on the length byte, then count bytes down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_left <= '0;
            crc_left <= '0;
        end else if (load) begin
            pay_left <= len_val;
            crc_left <= crc_en ? 2'(CRC_BYTES) : 2'd0;
        end else if (take) begin
            if (pay_left != '0)      pay_left <= pay_left - 1'b1;
            else if (crc_left != '0) crc_left <= crc_left - 1'b1;
        end
    end

    // Tag and last-byte flag for the byte about to be accepted
    always_comb begin
        cur_tag = (pay_left != '0) ? TAG_PAY : TAG_CRC;
        last    = ((pay_left == CNT_W'(1)) && (crc_left == 2'd0)) ||
                  ((pay_left == '0) && (crc_left == 2'd1));
    end

    a_r4_take_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((pay_left != '0) || (crc_left != '0)))
        else $error("R4: byte taken with nothing left to count");

    a_r4_crc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        crc_left <= 2'(CRC_BYTES))
        else $error("R4: CRC count above its bound");
endmodule

// File: rtl/rxf_gap_count.sv
// Gap counter: counts strobes in a row with no correlation while the
// packet has no length field. It flags expiry on the strobe that reaches
// the limit. A limit of zero never expires.
// Assumes: lim stays the same while run is high.
module rxf_gap_count #(
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sym_stb,
    input  logic             corr_hit,
    input  logic [LIM_W-1:0] lim,
    output logic             expire
);
    logic [LIM_W-1:0] cnt;
    logic [LIM_W:0]   cnt_inc;
    logic             miss;

    // Detect a miss strobe and whether it completes the run
    always_comb begin
        miss    = run && sym_stb && !corr_hit;
        cnt_inc = {1'b0, cnt} + {{LIM_W{1'b0}}, 1'b1};
        expire  = miss && (lim != '0) && (cnt_inc == {1'b0, lim});
    end

    // Count misses in a row; clear on a hit, on expiry or when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run)           cnt <= '0;
        else if (sym_stb) begin
            if (corr_hit || expire)   cnt <= '0;
            else                      cnt <= cnt + 1'b1;
        end
    end

    a_r5_cnt_below_lim: assert property (@(posedge clk) disable iff (!rst_n)
        (lim != '0) |-> (cnt < lim))
        else $error("R5: miss count passed its limit");
endmodule

// File: rtl/rx_pkt_framer.sv
// Receive packet framer top. A three-state controller (search, length,
// body) takes its start from the start detector. It ends a packet through
// the length tracker or through the gap counter and byte cap, and it
// registers every output.
// Assumes: configuration inputs are steady while a packet is active.
module rx_pkt_framer
    import rxf_pkg::*;
#(
    parameter int MAX_LEN = 40,
    parameter int BYTE_W  = 8,
    parameter int LIM_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_stb,
    input  logic              corr_hit,
    input  logic              sop_match,
    input  logic              din_vld,
    input  logic [BYTE_W-1:0] din,
    input  logic              cfg_framing_en,
    input  logic              cfg_len_en,
    input  logic              cfg_crc_en,
    input  logic [LIM_W-1:0]  cfg_gap_lim,
    output logic              pkt_active,
    output logic              dout_vld,
    output logic [BYTE_W-1:0] dout,
    output logic [1:0]        dout_tag,
    output logic              sop_pulse,
    output logic              eop_pulse,
    output logic              err_pulse
);
    localparam int              CNT_W = $clog2(MAX_LEN + 1);
    localparam logic [BYTE_W-1:0] MAX_B = BYTE_W'(MAX_LEN);

    typedef enum logic [1:0] {ST_SEARCH, ST_LEN, ST_BODY} st_e;

    st_e              state;
    logic             len_mode_q;
    logic [CNT_W-1:0] fcnt;
    tag_e             dout_tag_q;

    logic acc, len_mode, len_ok, len_empty, start;
    logic load, take, gap_run, gap_exp, cap_hit, trk_last;
    tag_e trk_tag;

    // Decode accepted bytes and length-field conditions
    always_comb begin
        acc       = sym_stb && din_vld;
        len_mode  = cfg_framing_en && cfg_len_en;
        len_ok    = (din <= MAX_B);
        len_empty = (din == '0) && !cfg_crc_en;
        load      = (state == ST_LEN) && acc && len_ok;
        take      = (state == ST_BODY) && len_mode_q && acc;
        gap_run   = (state == ST_BODY) && !len_mode_q;
        cap_hit   = gap_run && acc && (fcnt == CNT_W'(MAX_LEN - 1));
    end

    rxf_start_det u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (state == ST_SEARCH),
        .sym_stb    (sym_stb),
        .framing_en (cfg_framing_en),
        .sop_match  (sop_match),
        .corr_hit   (corr_hit),
        .start      (start)
    );

    rxf_len_track #(.CNT_W(CNT_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .take    (take),
        .crc_en  (cfg_crc_en),
        .len_val (din[CNT_W-1:0]),
        .cur_tag (trk_tag),
        .last    (trk_last)
    );

    rxf_gap_count #(.LIM_W(LIM_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gap_run),
        .sym_stb  (sym_stb),
        .corr_hit (corr_hit),
        .lim      (cfg_gap_lim),
        .expire   (gap_exp)
    );

    // Frame controller and registered output stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_SEARCH;
            len_mode_q <= 1'b0;
            fcnt       <= '0;
            dout_vld   <= 1'b0;
            dout       <= '0;
            dout_tag_q <= TAG_LEN;
            sop_pulse  <= 1'b0;
            eop_pulse  <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            sop_pulse <= 1'b0;
            eop_pulse <= 1'b0;
            err_pulse <= 1'b0;
            dout_vld  <= 1'b0;
            unique case (state)
                ST_SEARCH: begin
                    if (start) begin
                        sop_pulse  <= 1'b1;
                        len_mode_q <= len_mode;
                        fcnt       <= '0;
                        state      <= len_mode ? ST_LEN : ST_BODY;
                    end
                end
                ST_LEN: begin
                    if (acc) begin
                        dout_vld   <= 1'b1;
                        dout       <= din;
                        dout_tag_q <= TAG_LEN;
                        if (!len_ok) begin
                            err_pulse <= 1'b1;
                            state     <= ST_SEARCH;
                        end else if (len_empty) begin
                            eop_pulse <= 1'b1;
                            state     <= ST_SEARCH;
                        end else begin
                            state     <= ST_BODY;
                        end
                    end
                end
                ST_BODY: begin
                    if (len_mode_q) begin
                        if (acc) begin
                            dout_vld   <= 1'b1;
                            dout       <= din;
                            dout_tag_q <= trk_tag;
                            if (trk_last) begin
                                eop_pulse <= 1'b1;
                                state     <= ST_SEARCH;
                            end
                        end
                    end else begin
                        if (acc) begin
                            dout_vld   <= 1'b1;
                            dout       <= din;
                            dout_tag_q <= TAG_PAY;
                            fcnt       <= fcnt + 1'b1;
                        end
                        if (gap_exp || cap_hit) begin
                            eop_pulse <= 1'b1;
                            state     <= ST_SEARCH;
                        end
                    end
                end
                default: state <= ST_SEARCH;
            endcase
        end
    end

    // Drive status and tag ports from the controller state
    always_comb begin
        pkt_active = (state != ST_SEARCH);
        dout_tag   = dout_tag_q;
    end

    a_r1_sop_active: assert property (@(posedge clk) disable iff (!rst_n)
        sop_pulse |-> pkt_active)
        else $error("R1: start pulse without active packet");

    a_r7_eop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |-> !pkt_active)
        else $error("R7: still active at end pulse");

    a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (!pkt_active && !eop_pulse))
        else $error("R7: error pulse with active packet or end pulse");

    a_r3_err_len: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && (dout_tag == TAG_LEN) && (dout > MAX_B)) |-> err_pulse)
        else $error("R3: oversized length without error pulse");

    a_r8_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld || sop_pulse || eop_pulse || err_pulse) |-> $past(sym_stb))
        else $error("R8: output event without a preceding strobe");
endmodule

// File: tb/tb_rx_pkt_framer.sv
`timescale 1ns/1ps
module tb_rx_pkt_framer;
    localparam logic [1:0] T_LEN = 2'd0, T_PAY = 2'd1, T_CRC = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_stb = 0, corr_hit = 0, sop_match = 0, din_vld = 0;
    logic [7:0] din = '0;
    logic cfg_framing_en = 1, cfg_len_en = 1, cfg_crc_en = 1;
    logic [3:0] cfg_gap_lim = 4'd3;
    logic pkt_active, dout_vld, sop_pulse, eop_pulse, err_pulse;
    logic [7:0] dout;
    logic [1:0] dout_tag;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [13:0] expq[$];
    string       reqq[$];

    always #2.5 clk = ~clk;

    rx_pkt_framer dut (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .corr_hit(corr_hit),
        .sop_match(sop_match), .din_vld(din_vld), .din(din),
        .cfg_framing_en(cfg_framing_en), .cfg_len_en(cfg_len_en),
        .cfg_crc_en(cfg_crc_en), .cfg_gap_lim(cfg_gap_lim),
        .pkt_active(pkt_active), .dout_vld(dout_vld), .dout(dout),
        .dout_tag(dout_tag), .sop_pulse(sop_pulse), .eop_pulse(eop_pulse),
        .err_pulse(err_pulse)
    );

    task automatic check(input logic [13:0] act, input logic [13:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Item: {err, eop, sop, valid, tag[1:0], byte[7:0]}
    task automatic push(input bit e, input bit p, input bit s, input bit v,
                        input logic [1:0] t, input logic [7:0] b, input string req);
        expq.push_back({e, p, s, v, v ? t : 2'd0, v ? b : 8'd0});
        reqq.push_back(req);
    endtask

    // Monitor: pop and compare every output event
    always @(negedge clk) begin
        if (rst_n && (dout_vld || sop_pulse || eop_pulse || err_pulse)) begin
            logic [13:0] obs;
            obs = {err_pulse, eop_pulse, sop_pulse, dout_vld,
                   dout_vld ? dout_tag : 2'd0, dout_vld ? dout : 8'd0};
            if (expq.size() == 0) check(obs, 14'h0, "R7 unexpected event");
            else check(obs, expq.pop_front(), reqq.pop_front());
        end
    end

    task automatic stb(input bit c, input bit s, input bit v, input logic [7:0] b);
        @(negedge clk);
        sym_stb = 1; corr_hit = c; sop_match = s; din_vld = v; din = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sym_stb = 0; corr_hit = 0; sop_match = 0; din_vld = 0;
        end
    endtask

    // Non-strobe cycle with busy inputs: must be ignored (R8)
    task automatic noise();
        @(negedge clk);
        sym_stb = 0; corr_hit = 1; sop_match = 1; din_vld = 1; din = 8'hAA;
    endtask

    task automatic fstart(input string req);
        stb(0, 1, 0, 0);
        push(0, 0, 1, 0, 0, 0, req);
        stb(0, 1, 0, 0);
    endtask

    task automatic len_pkt(input int len, input string req);
        fstart("R1 marker start");
        push(len > 40, (len == 0) && !cfg_crc_en, 0, 1, T_LEN, 8'(len), req);
        stb(1, 0, 1, 8'(len));
        check({13'd0, pkt_active}, 14'd1, "R1 active after start");
        if (len <= 40) begin
            for (int i = 0; i < len; i++) begin
                push(0, (i == len - 1) && !cfg_crc_en, 0, 1, T_PAY, 8'(8'h10 + i), req);
                stb(1, 0, 1, 8'(8'h10 + i));
            end
            if (cfg_crc_en) begin
                push(0, 0, 0, 1, T_CRC, 8'hC1, req);
                stb(1, 0, 1, 8'hC1);
                push(0, 1, 0, 1, T_CRC, 8'hC2, req);
                stb(1, 0, 1, 8'hC2);
            end
        end
        idle(1);
        check({13'd0, pkt_active}, 14'd0, "R7 inactive after end");
        // Stray bytes and a lone marker after the end give no output (R7)
        stb(0, 0, 1, 8'h55);
        stb(0, 1, 0, 0);
        idle(2);
        check({13'd0, pkt_active}, 14'd0, "R7 lone marker ignored");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check({9'd0, pkt_active, dout_vld, sop_pulse, eop_pulse, err_pulse}, 14'd0, "R9 reset state");
        rst_n = 1;
        idle(2);

        // Length mode, with and without CRC, edge lengths
        cfg_framing_en = 1; cfg_len_en = 1; cfg_crc_en = 1;
        len_pkt(3, "R4 len3 crc");
        cfg_crc_en = 0;
        len_pkt(2, "R4 len2 nocrc");
        len_pkt(0, "R4 len0 nocrc");
        cfg_crc_en = 1;
        len_pkt(0, "R4 len0 crc");
        cfg_crc_en = 0;
        len_pkt(40, "R4 len40 max");
        len_pkt(41, "R3 len41 error");
        len_pkt(200, "R3 len200 error");

        // R1: hits alone and split markers do not start
        stb(1, 0, 0, 0); stb(1, 0, 0, 0); stb(1, 0, 0, 0);
        stb(0, 1, 0, 0); stb(0, 0, 0, 0); stb(0, 1, 0, 0); stb(1, 0, 0, 0);
        idle(2);
        check({13'd0, pkt_active}, 14'd0, "R1 no false start");

        // R8: non-strobe cycles between marker strobes do not break the pair
        stb(0, 1, 0, 0);
        noise(); noise();
        push(0, 0, 1, 0, 0, 0, "R8 pair across gap");
        stb(0, 1, 0, 0);
        noise();
        // Markers inside the packet do not restart it
        stb(1, 1, 0, 0); stb(1, 1, 0, 0);
        push(0, 0, 0, 1, T_LEN, 8'd1, "R8 no restart");
        stb(1, 1, 1, 8'd1);
        push(0, 1, 0, 1, T_PAY, 8'h77, "R8 packet intact");
        stb(1, 0, 1, 8'h77);
        idle(2);

        // R5: framed, no length field, miss run limit 3, hit clears the run
        cfg_len_en = 0; cfg_gap_lim = 4'd3;
        fstart("R5 start");
        push(0, 0, 0, 1, T_PAY, 8'h21, "R5 payload tag");
        stb(1, 0, 1, 8'h21);
        push(0, 0, 0, 1, T_PAY, 8'h22, "R5 byte on miss");
        stb(0, 0, 1, 8'h22);
        stb(0, 0, 0, 0);
        push(0, 0, 0, 1, T_PAY, 8'h23, "R5 hit clears run");
        stb(1, 0, 1, 8'h23);
        stb(0, 0, 0, 0);
        noise(); noise(); noise();
        stb(0, 0, 0, 0);
        check({13'd0, pkt_active}, 14'd1, "R5 still active at two misses");
        push(0, 1, 0, 0, 0, 0, "R5 end on third miss");
        stb(0, 0, 0, 0);
        idle(2);
        check({13'd0, pkt_active}, 14'd0, "R5 inactive after gap end");

        // R2: unframed start, length enable ignored, limit 2
        cfg_framing_en = 0; cfg_len_en = 1; cfg_gap_lim = 4'd2;
        stb(0, 1, 0, 0); stb(0, 1, 0, 0);
        stb(1, 0, 0, 0);
        push(0, 0, 1, 0, 0, 0, "R2 corr pair start");
        stb(1, 0, 0, 0);
        push(0, 0, 0, 1, T_PAY, 8'h05, "R2 first byte is payload");
        stb(1, 0, 1, 8'h05);
        stb(0, 0, 0, 0);
        push(0, 1, 0, 0, 0, 0, "R2 gap end");
        stb(0, 0, 0, 0);
        idle(2);

        // R6: limit 0, misses never end it; cap at 40 bytes
        cfg_gap_lim = 4'd0;
        stb(1, 0, 0, 0);
        push(0, 0, 1, 0, 0, 0, "R6 start");
        stb(1, 0, 0, 0);
        for (int i = 0; i < 40; i++) begin
            push(0, i == 39, 0, 1, T_PAY, 8'(i), "R6 cap at 40");
            stb(0, 0, 1, 8'(i));
            if (i == 20) stb(0, 0, 0, 0);
        end
        stb(0, 0, 1, 8'hEE); stb(0, 0, 1, 8'hEF);
        idle(3);
        check({13'd0, pkt_active}, 14'd0, "R6 inactive after cap");

        idle(3);
        check(14'(expq.size()), 14'd0, "R7 all expected events seen");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule